// File: doc/BRIEF.md
# Link L1 Entry Handshake Initiator

This block drives the downstream end of the exchange that takes a serial link out of its active state and into the L1 low-power state. It watches a link-idle indication, which reports that both directions of the link sit in standby, together with a flag that says the transaction layer still has work queued. Once the link has stayed idle with nothing pending for a programmable number of cycles, the block starts a request.

While the request is open, the block repeatedly asks the link layer to transmit an L1 request packet. The spacing between copies is programmable, so ordinary traffic still gets slots. The request closes in one of three ways:

- An acknowledge from the upstream side closes the transmit gate and idles the lanes. The L1 indication follows one cycle later.
- A reject returns the block to the active state.
- If no reply arrives within a programmable timeout, the block also returns to the active state.

While the link is in L1, a wake request reopens the transmit gate, takes the lanes out of electrical idle and emits a one-cycle exit pulse toward link recovery.

Top module: `l1_entry_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `pkt_send`, `tx_block`, `tx_elec_idle`, `l1_active` and `exit_req` are 0. `pkt_type` reads 0.
- R2: A request opens at the clock edge that completes `idle_limit` consecutive cycles in the active state with `link_idle`=1 and `tl_pending`=0. `pkt_send` rises in the cycle after that edge. Any cycle that breaks this condition restarts the count from zero.
- R3: In the first cycle of an open request, `pkt_send` is 1. After that it repeats every `gap_limit`+1 cycles. Whenever `pkt_send` is 1, `pkt_type` is 4'h4 (the L1 request code). Whenever `pkt_send` is 0, `pkt_type` is 4'h0.
- R4: `rx_nak` during an open request returns the block to the active state at the next edge, with `pkt_send`=0 and `tx_block`=0. If `rx_nak` and `rx_ack` are both 1 in the same cycle, the reject wins.
- R5: `rx_ack` alone during an open request sets `tx_block`=1 and `tx_elec_idle`=1 at the next edge. From that edge on, no further request packet is sent, and `l1_active` is still 0.
- R6: `l1_active` rises exactly one cycle after `tx_elec_idle` rises, and `l1_active` is never 1 while `tx_elec_idle` is 0.
- R7: If an open request has lasted `reply_timeout` cycles with no reply, the block returns to the active state at the edge that ends the last of those cycles. A reply sampled at that same edge takes precedence over the timeout.
- R8: `wake_req` in L1 sets `tx_block`, `tx_elec_idle` and `l1_active` to 0 at the next edge and pulses `exit_req` for exactly one cycle. The block is then active, and its idle count starts again from zero.
- R9: `rx_ack` and `rx_nak` have no effect outside an open request. `wake_req` has no effect outside L1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_idle | input | 1 | Both link directions are in standby |
| tl_pending | input | 1 | Transaction layer has queued work |
| idle_limit | input | CW | Idle cycles required before a request |
| gap_limit | input | CW | Cycles between request packet copies |
| reply_timeout | input | CW | Request cycles allowed without a reply |
| rx_ack | input | 1 | Acknowledge packet received |
| rx_nak | input | 1 | Reject received |
| wake_req | input | 1 | Request to leave L1 |
| pkt_send | output | 1 | Ask link layer to send a packet this cycle |
| pkt_type | output | 4 | Type code of the packet to send |
| tx_block | output | 1 | Link- and transaction-layer transmission disabled |
| tx_elec_idle | output | 1 | Transmit lanes held in electrical idle |
| l1_active | output | 1 | Link is in L1 |
| exit_req | output | 1 | One-cycle pulse asking for recovery |

## Verification
Two events can coincide inside an open request.

- **Reply on the timeout cycle.** A reply can land in the very cycle the reply timeout expires. The bench places an acknowledge on the last allowed request cycle, and a correct block must then close the gate instead of going back to active. The bench also sweeps the timeout itself across several small values to pin the exact expiry edge.
- **Acknowledge and reject together.** Both replies can assert in one cycle. The bench drives them together and expects the reject to win, which leaves the gate open and the packet stream stopped.

// File: rtl/l1e_pkg.sv
package l1e_pkg;

    localparam int PKT_W = 4;
    localparam logic [PKT_W-1:0] PKT_NONE   = 4'h0;
    localparam logic [PKT_W-1:0] PKT_L1_REQ = 4'h4;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_REQ,
        ST_EIDLE,
        ST_L1,
        ST_EXIT
    } l1e_state_e;

    typedef struct packed {
        logic block;
        logic eidle;
        logic l1;
        logic exit_p;
    } l1e_drive_t;

    function automatic l1e_drive_t drive_of(l1e_state_e s);
        l1e_drive_t d;
        d = '0;
        case (s)
            ST_EIDLE: begin d.block = 1'b1; d.eidle = 1'b1; end
            ST_L1:    begin d.block = 1'b1; d.eidle = 1'b1; d.l1 = 1'b1; end
            ST_EXIT:  d.exit_p = 1'b1;
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/l1e_idle_timer.sv
module l1e_idle_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          idle_ok,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign hit     = run && idle_ok && (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !run || !idle_ok) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt_inc[CW-1:0];
        end
    end
endmodule

// File: rtl/l1e_req_pacer.sv
module l1e_req_pacer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          open,
    input  logic [CW-1:0] gap_limit,
    input  logic [CW-1:0] to_limit,
    output logic          send,
    output logic          expired
);
    logic [CW-1:0] gap_cnt;
    logic [CW-1:0] age;
    logic [CW:0]   age_inc;

    assign age_inc = {1'b0, age} + 1'b1;
    assign send    = open && (gap_cnt == '0);
    assign expired = open && (age_inc >= {1'b0, to_limit});

    always_ff @(posedge clk) begin
        if (rst || !open) begin
            gap_cnt <= '0;
            age     <= '0;
        end else begin
            gap_cnt <= send ? gap_limit : gap_cnt - 1'b1;
            if (age != '1) begin
                age <= age_inc[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/l1_entry_ctrl.sv
module l1_entry_ctrl
    import l1e_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_idle,
    input  logic             tl_pending,
    input  logic [CW-1:0]    idle_limit,
    input  logic [CW-1:0]    gap_limit,
    input  logic [CW-1:0]    reply_timeout,
    input  logic             rx_ack,
    input  logic             rx_nak,
    input  logic             wake_req,
    output logic             pkt_send,
    output logic [PKT_W-1:0] pkt_type,
    output logic             tx_block,
    output logic             tx_elec_idle,
    output logic             l1_active,
    output logic             exit_req
);
    l1e_state_e state, state_nxt;
    l1e_drive_t drv;
    logic       idle_hit, send, expired;

    l1e_idle_timer #(.CW(CW)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_ACTIVE),
        .idle_ok (link_idle && !tl_pending),
        .limit   (idle_limit),
        .hit     (idle_hit)
    );

    l1e_req_pacer #(.CW(CW)) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .open      (state == ST_REQ),
        .gap_limit (gap_limit),
        .to_limit  (reply_timeout),
        .send      (send),
        .expired   (expired)
    );

    always_comb begin
        state_nxt = state;
        case (state)
            ST_ACTIVE: if (idle_hit) state_nxt = ST_REQ;
            ST_REQ: begin
                if (rx_nak)       state_nxt = ST_ACTIVE;
                else if (rx_ack)  state_nxt = ST_EIDLE;
                else if (expired) state_nxt = ST_ACTIVE;
            end
            ST_EIDLE:  state_nxt = ST_L1;
            ST_L1:     if (wake_req) state_nxt = ST_EXIT;
            ST_EXIT:   state_nxt = ST_ACTIVE;
            default:   state_nxt = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ACTIVE;
        else     state <= state_nxt;
    end

    assign drv          = drive_of(state);
    assign pkt_send     = send;
    assign pkt_type     = send ? PKT_L1_REQ : PKT_NONE;
    assign tx_block     = drv.block;
    assign tx_elec_idle = drv.eidle;
    assign l1_active    = drv.l1;
    assign exit_req     = drv.exit_p;
endmodule

// File: rtl/l1e_checker.sv
module l1e_checker (
    input logic clk,
    input logic rst,
    input logic rx_ack,
    input logic rx_nak,
    input logic wake_req,
    input logic pkt_send,
    input logic tx_block,
    input logic tx_elec_idle,
    input logic l1_active,
    input logic exit_req
);
    p_ack_idles_r5: assert property (@(posedge clk) disable iff (rst)
        pkt_send && rx_ack && !rx_nak |=> tx_block && tx_elec_idle && !l1_active);

    p_gate_stops_send_r5: assert property (@(posedge clk) disable iff (rst)
        tx_block |-> !pkt_send);

    p_nak_returns_r4: assert property (@(posedge clk) disable iff (rst)
        pkt_send && rx_nak |=> !pkt_send && !tx_block && !tx_elec_idle);

    p_l1_needs_idle_r6: assert property (@(posedge clk) disable iff (rst)
        l1_active |-> tx_elec_idle);

    p_l1_after_idle_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_elec_idle) |=> l1_active);

    p_wake_exit_r8: assert property (@(posedge clk) disable iff (rst)
        l1_active && wake_req |=> exit_req && !tx_block && !tx_elec_idle && !l1_active);

    p_exit_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        exit_req |=> !exit_req);
endmodule

bind l1_entry_ctrl l1e_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_ack       (rx_ack),
    .rx_nak       (rx_nak),
    .wake_req     (wake_req),
    .pkt_send     (pkt_send),
    .tx_block     (tx_block),
    .tx_elec_idle (tx_elec_idle),
    .l1_active    (l1_active),
    .exit_req     (exit_req)
);

// File: tb/l1_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module l1_entry_ctrl_tb_top;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          link_idle = 1'b0, tl_pending = 1'b0;
    logic [CW-1:0] idle_limit = 8'd1, gap_limit = 8'd0, reply_timeout = 8'd50;
    logic          rx_ack = 1'b0, rx_nak = 1'b0, wake_req = 1'b0;
    logic          pkt_send, tx_block, tx_elec_idle, l1_active, exit_req;
    logic [3:0]    pkt_type;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    l1_entry_ctrl #(.CW(CW)) dut_i (
        .clk(clk), .rst(rst), .link_idle(link_idle), .tl_pending(tl_pending),
        .idle_limit(idle_limit), .gap_limit(gap_limit), .reply_timeout(reply_timeout),
        .rx_ack(rx_ack), .rx_nak(rx_nak), .wake_req(wake_req),
        .pkt_send(pkt_send), .pkt_type(pkt_type), .tx_block(tx_block),
        .tx_elec_idle(tx_elec_idle), .l1_active(l1_active), .exit_req(exit_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // packed view of the four state outputs: {block, eidle, l1, exit}
    function automatic int outs();
        return {tx_block, tx_elec_idle, l1_active, exit_req};
    endfunction

    // open a request with an idle limit of one; returns at request cycle 0
    task automatic enter_req();
        idle_limit = 8'd1;
        link_idle  = 1'b1;
        tick();
        link_idle  = 1'b0;
    endtask

    task automatic nak_back();
        rx_nak = 1'b1;
        tick();
        rx_nak = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk("R1 outputs in reset", outs(), 0);
        rst = 1'b0;
        tick();
        chk("R1 outputs after reset", outs(), 0);
        chk("R1 pkt_send after reset", pkt_send, 0);
        chk("R1 pkt_type after reset", pkt_type, 0);

        // R2: plain idle run, then interrupted run
        for (int lim = 1; lim <= 5; lim++) begin
            idle_limit = lim[CW-1:0];
            link_idle  = 1'b1;
            for (int k = 1; k <= lim; k++) begin
                tick();
                chk("R2 idle threshold", pkt_send, (k == lim) ? 1 : 0);
            end
            link_idle = 1'b0;
            nak_back();
        end
        for (int lim = 2; lim <= 5; lim++) begin
            idle_limit = lim[CW-1:0];
            link_idle  = 1'b1;
            for (int k = 1; k < lim; k++) begin
                tick();
                chk("R2 before interrupt", pkt_send, 0);
            end
            if (lim % 2 == 0) tl_pending = 1'b1;
            else              link_idle  = 1'b0;
            tick();
            chk("R2 interrupt cycle", pkt_send, 0);
            tl_pending = 1'b0;
            link_idle  = 1'b1;
            for (int k = 1; k <= lim; k++) begin
                tick();
                chk("R2 restarted count", pkt_send, (k == lim) ? 1 : 0);
            end
            link_idle = 1'b0;
            nak_back();
        end

        // R3: packet spacing and type code
        reply_timeout = 8'd50;
        for (int g = 0; g <= 3; g++) begin
            gap_limit = g[CW-1:0];
            enter_req();
            for (int i = 0; i < 12; i++) begin
                chk("R3 send pattern", pkt_send, (i % (g + 1) == 0) ? 1 : 0);
                chk("R3 type code", pkt_type, (i % (g + 1) == 0) ? 4 : 0);
                tick();
            end
            nak_back();
            chk("R4 nak stops send", pkt_send, 0);
            chk("R4 nak leaves gate open", tx_block, 0);
            tick();
            chk("R4 stays active", pkt_send, 0);
        end

        // R7: timeout sweep
        gap_limit = 8'd0;
        for (int t = 1; t <= 6; t++) begin
            reply_timeout = t[CW-1:0];
            enter_req();
            for (int i = 0; i <= t + 1; i++) begin
                chk("R7 timeout window", pkt_send, (i < t) ? 1 : 0);
                chk("R7 gate open", tx_block, 0);
                tick();
            end
        end

        // R7: acknowledge on the expiring cycle wins
        reply_timeout = 8'd4;
        enter_req();
        repeat (3) tick();
        rx_ack = 1'b1;
        tick();
        rx_ack = 1'b0;
        chk("R7 ack beats timeout", tx_block, 1);
        tick();
        chk("R7 then L1", l1_active, 1);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        chk("R8 exit after timeout case", outs(), 1);
        tick();

        // R5 / R6 / R9 / R8: acknowledge path
        reply_timeout = 8'd50;
        enter_req();
        rx_ack = 1'b1;
        tick();
        rx_ack = 1'b0;
        chk("R5 gate and idle on ack", outs(), 12);
        chk("R5 no send after ack", pkt_send, 0);
        tick();
        chk("R6 l1 one cycle later", outs(), 14);
        rx_ack = 1'b1;
        rx_nak = 1'b1;
        link_idle = 1'b1;
        idle_limit = 8'd2;
        tick();
        rx_ack = 1'b0;
        rx_nak = 1'b0;
        chk("R9 replies ignored in L1", outs(), 14);
        chk("R9 no send in L1", pkt_send, 0);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        chk("R8 wake exit pulse", outs(), 1);
        tick();
        chk("R8 exit one cycle", outs(), 0);
        chk("R8 idle count restarted a", pkt_send, 0);
        tick();
        chk("R8 idle count restarted b", pkt_send, 0);
        tick();
        chk("R8 idle count restarted c", pkt_send, 1);
        link_idle = 1'b0;
        nak_back();

        // R4: both replies in one cycle
        enter_req();
        rx_ack = 1'b1;
        rx_nak = 1'b1;
        tick();
        rx_ack = 1'b0;
        rx_nak = 1'b0;
        chk("R4 nak wins over ack", outs(), 0);
        chk("R4 no send", pkt_send, 0);

        // R9: replies and wake ignored while active
        rx_ack = 1'b1;
        wake_req = 1'b1;
        tick();
        rx_ack = 1'b0;
        wake_req = 1'b0;
        chk("R9 ignored while active", outs(), 0);
        tick();
        chk("R9 still active", outs(), 0);
        chk("R9 no send while active", pkt_send, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule